// File: doc/BRIEF.md
# Fetch-Counting Deadman Timer

This block watches a processor for loss of control flow. It counts fetch strobes rather than clock cycles. Once the count reaches a programmable limit, it declares a deadman event and pulses a reset request. Software keeps the timer quiet by servicing it in two ordered steps. First it writes an arming key to the pre-clear register. Then, once the status register shows that the service window is open, it writes a second key to the clear register. The window opens when the counter has come within a programmable interval of the limit.

Any arming write with the wrong key raises a fault. So does any clear write that is wrong, that comes before a valid arming key, or that comes before the window opens. Each fault latches sticky status flags, pulses the reset request for one cycle and sets a cause bit. Software clears the cause bit by writing a one to it. Clearing the enable bit blocks all writes during the next cycle.

Top module: `dmt_core`

## Requirements
- R1: Register offsets are: control at 0x00 (enable at bit 15), pre-clear at 0x10, clear at 0x20, status at 0x30, counter at 0x40 (read-only), cause at 0x50, limit at 0x60 and interval at 0x70. After reset, control, status, counter and cause read 0, and limit and interval read their parameter values. Limit and interval read back what was written.
- R2: While enable is 1, the counter increases by one for each cycle in which the fetch strobe is high. While enable is 0, fetch strobes leave the counter unchanged.
- R3: Status bit 0 (window open) reads 1 exactly when enable is 1 and counter + interval >= limit.
- R4: A pre-clear write arms the key latch when bits 15:8 equal 0x40; bits 7:0 are ignored. Any other value sets status bit 7 (bad first key) and status bit 5 (event).
- R5: A clear write whose bits 7:0 equal 0x08, made while the latch is armed and the window is open, sets the counter to 0 and disarms the latch. A second clear without a new arming key is therefore a fault.
- R6: A clear write with the wrong key, with no armed latch, or with the window closed sets status bit 6 (bad second key) and bit 5, and leaves the counter unchanged. Status flags stay set until reset.
- R7: When a fetch strobe would bring the counter to the limit or beyond, status bit 5 is set and the counter returns to 0. A valid clear in the same cycle takes precedence.
- R8: Every fault raises rst_req_o for exactly one cycle and sets cause bit 5. Writing 1 to cause bit 5 clears it.
- R9: A control write that changes enable from 1 to 0 causes every write in the following cycle to be ignored.
- R10: Pre-clear and clear writes made while enable is 0 have no effect: no flag, no pulse, no counter change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_i | input | 1 | One pulse per instruction fetch |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| rst_req_o | output | 1 | One-cycle reset request on a deadman event |

## Verification
The bench builds the block with a limit of 20 and an interval of 5. With those values, window opening, expiry and counter wrap all happen within a few dozen fetch strobes. It then reprograms the limit to 8 and the interval to 3 to show that both registers act at run time. A window of five counts leaves room to place a clear both before and inside the window. The small limit lets the bench reach expiry by exact counts. The bench resets the design between fault scenarios, so that the sticky flags of one scenario do not hide those of the next.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    // Register offsets; software decodes these, so they are fixed.
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ARM   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_CAUSE = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_LIMIT = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_SPAN  = 8'h70;

    localparam int BIT_ON     = 15;
    localparam int BIT_WIN    = 0;
    localparam int BIT_EVT    = 5;
    localparam int BIT_BAD2   = 6;
    localparam int BIT_BAD1   = 7;
    localparam int BIT_CAUSE  = 5;

    localparam logic [7:0] ARM_KEY = 8'h40;
    localparam logic [7:0] CLR_KEY = 8'h08;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_ARM,
        SEL_CLR,
        SEL_STAT,
        SEL_CNT,
        SEL_CAUSE,
        SEL_LIMIT,
        SEL_SPAN
    } reg_sel_e;

    typedef struct packed {
        logic ctrl;
        logic arm;
        logic clr;
        logic cause;
        logic limit;
        logic span;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    typedef struct packed {
        logic bad1;
        logic bad2;
        logic expire;
    } fault_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CTRL:  return SEL_CTRL;
            OFS_ARM:   return SEL_ARM;
            OFS_CLR:   return SEL_CLR;
            OFS_STAT:  return SEL_STAT;
            OFS_CNT:   return SEL_CNT;
            OFS_CAUSE: return SEL_CAUSE;
            OFS_LIMIT: return SEL_LIMIT;
            OFS_SPAN:  return SEL_SPAN;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic any_fault(input fault_t f);
        return f.bad1 | f.bad2 | f.expire;
    endfunction

endpackage

// File: rtl/dmt_bus.sv
module dmt_bus
    import dmt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] LIMIT_INIT = '1,
    parameter logic [CNT_W-1:0] SPAN_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output wr_cmd_t           cmd_o,
    output logic              on_o,
    output logic [CNT_W-1:0]  limit_o,
    output logic [CNT_W-1:0]  span_o
);

    logic             on_q;
    logic             lock_q;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] span_q;
    reg_sel_e         sel;
    logic             accept;

    always_comb begin
        sel          = decode_addr(addr_i);
        accept       = we_i & ~lock_q;
        cmd_o.ctrl   = accept & (sel == SEL_CTRL);
        cmd_o.arm    = accept & (sel == SEL_ARM);
        cmd_o.clr    = accept & (sel == SEL_CLR);
        cmd_o.cause  = accept & (sel == SEL_CAUSE);
        cmd_o.limit  = accept & (sel == SEL_LIMIT);
        cmd_o.span   = accept & (sel == SEL_SPAN);
        cmd_o.data   = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q    <= 1'b0;
            lock_q  <= 1'b0;
            limit_q <= LIMIT_INIT;
            span_q  <= SPAN_INIT;
        end else begin
            lock_q <= cmd_o.ctrl & on_q & ~wdata_i[BIT_ON];
            if (cmd_o.ctrl)  on_q    <= wdata_i[BIT_ON];
            if (cmd_o.limit) limit_q <= wdata_i[CNT_W-1:0];
            if (cmd_o.span)  span_q  <= wdata_i[CNT_W-1:0];
        end
    end

    assign on_o    = on_q;
    assign limit_o = limit_q;
    assign span_o  = span_q;

    // R9: the cycle after disabling leaves configuration untouched
    p_lock_hold_r9: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> ($stable(limit_q) && $stable(span_q) && $stable(on_q)));

endmodule

// File: rtl/dmt_count.sv
module dmt_count
    import dmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             on_i,
    input  logic             fetch_i,
    input  logic             clr_ok_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic [CNT_W-1:0] span_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             win_open_o,
    output logic             expire_o
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] cnt_next;
    logic [EXT_W-1:0] reach;
    logic             step;

    always_comb begin
        step       = on_i & fetch_i;
        cnt_next   = {1'b0, cnt_q} + EXT_W'(1);
        reach      = {1'b0, cnt_q} + {1'b0, span_i};
        win_open_o = on_i & (reach >= {1'b0, limit_i});
        expire_o   = step & ~clr_ok_i & (cnt_next >= {1'b0, limit_i});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr_ok_i || expire_o) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_next[CNT_W-1:0];
        end
    end

    assign cnt_o = cnt_q;

    // R2: no counting while disabled
    p_hold_off_r2: assert property (@(posedge clk) disable iff (rst)
        !on_i |=> $stable(cnt_q));

    // R5: accepted key pair restarts the count
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
        clr_ok_i |=> (cnt_q == '0));

    // R7: expiry wraps the counter
    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> (cnt_q == '0));

endmodule

// File: rtl/dmt_keys.sv
module dmt_keys
    import dmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              on_i,
    input  logic              arm_wr_i,
    input  logic              clr_wr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              win_open_i,
    output logic              clr_ok_o,
    output logic              bad1_o,
    output logic              bad2_o
);

    logic arm_q;
    logic arm_hit;
    logic clr_hit;

    always_comb begin
        arm_hit  = (data_i[15:8] == ARM_KEY);
        clr_hit  = (data_i[7:0] == CLR_KEY) & arm_q & win_open_i;
        bad1_o   = on_i & arm_wr_i & ~arm_hit;
        bad2_o   = on_i & clr_wr_i & ~clr_hit;
        clr_ok_o = on_i & clr_wr_i & clr_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b0;
        end else if (on_i && clr_wr_i) begin
            arm_q <= 1'b0;
        end else if (on_i && arm_wr_i && arm_hit) begin
            arm_q <= 1'b1;
        end
    end

    // R5: a used pair must be re-armed
    p_disarm_r5: assert property (@(posedge clk) disable iff (rst)
        clr_ok_o |=> !arm_q);

    // R10: key writes are inert while disabled
    p_off_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (!on_i && (arm_wr_i || clr_wr_i)) |=> $stable(arm_q));

endmodule

// File: rtl/dmt_core.sv
module dmt_core
    import dmt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] LIMIT_INIT = 16'd4096,
    parameter logic [CNT_W-1:0] SPAN_INIT = 16'd512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_i,
    input  logic        we_i,
    input  logic [7:0]  addr_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rdata_o,
    output logic        rst_req_o
);

    localparam int PAD_W = DATA_W - CNT_W;

    wr_cmd_t           cmd;
    fault_t            fault;
    logic              on;
    logic [CNT_W-1:0]  limit;
    logic [CNT_W-1:0]  span;
    logic [CNT_W-1:0]  cnt;
    logic              win_open;
    logic              clr_ok;
    logic [DATA_W-1:0] cnt_ext;
    logic [DATA_W-1:0] limit_ext;
    logic [DATA_W-1:0] span_ext;

    logic st_evt_q;
    logic st_bad1_q;
    logic st_bad2_q;
    logic cause_q;
    logic pulse_q;

    dmt_bus #(
        .CNT_W      (CNT_W),
        .LIMIT_INIT (LIMIT_INIT),
        .SPAN_INIT  (SPAN_INIT)
    ) u_bus (
        .clk     (clk),
        .rst     (rst),
        .we_i    (we_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .cmd_o   (cmd),
        .on_o    (on),
        .limit_o (limit),
        .span_o  (span)
    );

    dmt_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst        (rst),
        .on_i       (on),
        .fetch_i    (fetch_i),
        .clr_ok_i   (clr_ok),
        .limit_i    (limit),
        .span_i     (span),
        .cnt_o      (cnt),
        .win_open_o (win_open),
        .expire_o   (fault.expire)
    );

    dmt_keys u_keys (
        .clk        (clk),
        .rst        (rst),
        .on_i       (on),
        .arm_wr_i   (cmd.arm),
        .clr_wr_i   (cmd.clr),
        .data_i     (cmd.data),
        .win_open_i (win_open),
        .clr_ok_o   (clr_ok),
        .bad1_o     (fault.bad1),
        .bad2_o     (fault.bad2)
    );

    generate
        if (PAD_W == 0) begin : g_full
            assign cnt_ext   = cnt;
            assign limit_ext = limit;
            assign span_ext  = span;
        end else begin : g_pad
            assign cnt_ext   = {{PAD_W{1'b0}}, cnt};
            assign limit_ext = {{PAD_W{1'b0}}, limit};
            assign span_ext  = {{PAD_W{1'b0}}, span};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            st_evt_q  <= 1'b0;
            st_bad1_q <= 1'b0;
            st_bad2_q <= 1'b0;
            cause_q   <= 1'b0;
            pulse_q   <= 1'b0;
        end else begin
            pulse_q <= any_fault(fault);
            if (any_fault(fault)) st_evt_q  <= 1'b1;
            if (fault.bad1)       st_bad1_q <= 1'b1;
            if (fault.bad2)       st_bad2_q <= 1'b1;
            if (any_fault(fault))
                cause_q <= 1'b1;
            else if (cmd.cause && cmd.data[BIT_CAUSE])
                cause_q <= 1'b0;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (decode_addr(addr_i))
            SEL_CTRL:  rdata_o[BIT_ON] = on;
            SEL_STAT: begin
                rdata_o[BIT_WIN]  = win_open;
                rdata_o[BIT_EVT]  = st_evt_q;
                rdata_o[BIT_BAD2] = st_bad2_q;
                rdata_o[BIT_BAD1] = st_bad1_q;
            end
            SEL_CNT:   rdata_o = cnt_ext;
            SEL_CAUSE: rdata_o[BIT_CAUSE] = cause_q;
            SEL_LIMIT: rdata_o = limit_ext;
            SEL_SPAN:  rdata_o = span_ext;
            default:   rdata_o = '0;
        endcase
    end

    assign rst_req_o = pulse_q;

    // R8: a reset request always comes with the event flag and the cause bit
    p_pulse_flags_r8: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> (st_evt_q && cause_q));

    // R6: status flags are sticky
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (st_bad2_q || st_bad1_q) |=> st_evt_q);

    // R7: expiry is always reported
    p_expire_flag_r7: assert property (@(posedge clk) disable iff (rst)
        fault.expire |=> (st_evt_q && pulse_q));

endmodule

// File: tb/tb_dmt_core.sv
module tb_dmt_core;

    localparam logic [3:0] OP_WR = 4'd1;
    localparam logic [3:0] OP_RD = 4'd2;
    localparam logic [3:0] OP_FE = 4'd3;
    localparam logic [3:0] OP_PU = 4'd4;
    localparam logic [3:0] OP_RS = 4'd5;
    localparam int NV = 62;

    // {requirement, op, address, data/expected/count}
    localparam logic [31:0] VEC [NV] = '{
        {4'd2,  OP_FE, 8'h00, 16'd3},     // R2 strobes while disabled
        {4'd2,  OP_RD, 8'h40, 16'd0},     // R2
        {4'd1,  OP_WR, 8'h00, 16'h8000},  // R1 enable
        {4'd1,  OP_RD, 8'h00, 16'h8000},  // R1
        {4'd2,  OP_FE, 8'h00, 16'd10},    // R2
        {4'd2,  OP_RD, 8'h40, 16'd10},    // R2
        {4'd3,  OP_RD, 8'h30, 16'h0000},  // R3 window closed
        {4'd4,  OP_WR, 8'h10, 16'h4000},  // R4 arm
        {4'd2,  OP_FE, 8'h00, 16'd5},     // R2
        {4'd3,  OP_RD, 8'h30, 16'h0001},  // R3 window open
        {4'd5,  OP_WR, 8'h20, 16'h0008},  // R5 valid clear
        {4'd5,  OP_RD, 8'h40, 16'd0},     // R5
        {4'd5,  OP_RD, 8'h30, 16'h0000},  // R5
        {4'd8,  OP_PU, 8'h00, 16'd0},     // R8 no pulse yet
        {4'd2,  OP_FE, 8'h00, 16'd15},    // R2
        {4'd6,  OP_WR, 8'h20, 16'h0008},  // R6 clear without re-arm
        {4'd6,  OP_RD, 8'h30, 16'h0061},  // R6
        {4'd8,  OP_PU, 8'h00, 16'd1},     // R8
        {4'd8,  OP_RD, 8'h50, 16'h0020},  // R8 cause set
        {4'd8,  OP_WR, 8'h50, 16'h0020},  // R8 write one to clear
        {4'd8,  OP_RD, 8'h50, 16'h0000},  // R8
        {4'd6,  OP_RS, 8'h00, 16'd0},
        {4'd1,  OP_WR, 8'h00, 16'h8000},
        {4'd4,  OP_WR, 8'h10, 16'h4100},  // R4 bad first key
        {4'd4,  OP_RD, 8'h30, 16'h00A0},  // R4
        {4'd6,  OP_RS, 8'h00, 16'd0},
        {4'd1,  OP_WR, 8'h00, 16'h8000},
        {4'd2,  OP_FE, 8'h00, 16'd10},
        {4'd4,  OP_WR, 8'h10, 16'h4000},
        {4'd6,  OP_WR, 8'h20, 16'h0008},  // R6 clear before window
        {4'd6,  OP_RD, 8'h30, 16'h0060},  // R6
        {4'd6,  OP_RS, 8'h00, 16'd0},
        {4'd1,  OP_WR, 8'h00, 16'h8000},
        {4'd4,  OP_WR, 8'h10, 16'h40FF},  // R4 low byte ignored
        {4'd2,  OP_FE, 8'h00, 16'd15},
        {4'd6,  OP_WR, 8'h20, 16'h0009},  // R6 wrong second key
        {4'd6,  OP_RD, 8'h30, 16'h0061},  // R6
        {4'd6,  OP_RD, 8'h40, 16'd15},    // R6 counter kept
        {4'd7,  OP_RS, 8'h00, 16'd0},
        {4'd1,  OP_WR, 8'h00, 16'h8000},
        {4'd7,  OP_FE, 8'h00, 16'd19},    // R7 one short of limit
        {4'd7,  OP_RD, 8'h30, 16'h0001},  // R7
        {4'd7,  OP_FE, 8'h00, 16'd1},     // R7 reach limit
        {4'd7,  OP_RD, 8'h40, 16'd0},     // R7 wrapped
        {4'd7,  OP_RD, 8'h30, 16'h0020},  // R7 event
        {4'd8,  OP_PU, 8'h00, 16'd1},     // R8
        {4'd8,  OP_RD, 8'h50, 16'h0020},  // R8
        {4'd1,  OP_WR, 8'h60, 16'h0008},  // R1 limit
        {4'd1,  OP_RD, 8'h60, 16'h0008},  // R1
        {4'd1,  OP_WR, 8'h70, 16'h0003},  // R1 interval
        {4'd1,  OP_RD, 8'h70, 16'h0003},  // R1
        {4'd3,  OP_FE, 8'h00, 16'd5},     // R3
        {4'd3,  OP_RD, 8'h30, 16'h0021},  // R3 open with new values
        {4'd7,  OP_FE, 8'h00, 16'd3},     // R7 expire at new limit
        {4'd7,  OP_RD, 8'h40, 16'd0},     // R7
        {4'd8,  OP_PU, 8'h00, 16'd2},     // R8 two pulses
        {4'd9,  OP_WR, 8'h00, 16'h0000},  // R9 disable
        {4'd9,  OP_WR, 8'h60, 16'h0030},  // R9 blocked write
        {4'd9,  OP_RD, 8'h60, 16'h0008},  // R9
        {4'd10, OP_RS, 8'h00, 16'd0},
        {4'd10, OP_WR, 8'h10, 16'h1100},  // R10 bad key while off
        {4'd10, OP_RD, 8'h30, 16'h0000}   // R10
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        fetch;
    logic        we;
    logic [7:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;

    always #2.5 clk = ~clk;

    dmt_core #(
        .CNT_W      (16),
        .LIMIT_INIT (16'd20),
        .SPAN_INIT  (16'd5)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .fetch_i   (fetch),
        .we_i      (we),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .rst_req_o (rst_req)
    );

    always @(negedge clk) if (rst_req) pulses <= pulses + 1;

    task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_edge();
        @(negedge clk);
        we = 1'b0;
        fetch = 1'b0;
    endtask

    task automatic do_reset();
        idle_edge();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        pulses = 0;
    endtask

    task automatic rd_chk(input int req, input logic [7:0] a, input logic [15:0] exp);
        idle_edge();
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    initial begin
        rst = 1'b1; fetch = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        do_reset();

        // R1 reset state
        rd_chk(1, 8'h00, 16'h0000);
        rd_chk(1, 8'h30, 16'h0000);
        rd_chk(1, 8'h40, 16'h0000);
        rd_chk(1, 8'h50, 16'h0000);
        rd_chk(1, 8'h60, 16'd20);
        rd_chk(1, 8'h70, 16'd5);
        chk(1, {15'd0, rst_req}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            logic [3:0]  rq;
            logic [3:0]  op;
            logic [7:0]  ad;
            logic [15:0] dv;
            {rq, op, ad, dv} = VEC[i];
            case (op)
                OP_WR: begin
                    idle_edge();
                    we = 1'b1; addr = ad; wdata = dv;
                end
                OP_RD: rd_chk(int'(rq), ad, dv);
                OP_FE: begin
                    for (int k = 0; k < int'(dv); k++) begin
                        idle_edge();
                        fetch = 1'b1;
                    end
                end
                OP_PU: begin
                    idle_edge();
                    #1;
                    chk(int'(rq), 16'(pulses), dv);
                end
                OP_RS: do_reset();
                default: ;
            endcase
        end

        // R8 directed: pulse lasts exactly one cycle
        do_reset();
        idle_edge();
        we = 1'b1; addr = 8'h00; wdata = 16'h8000;
        idle_edge();
        we = 1'b1; addr = 8'h10; wdata = 16'h2200;
        idle_edge();
        #1;
        chk(8, {15'd0, rst_req}, 16'd1);
        idle_edge();
        #1;
        chk(8, {15'd0, rst_req}, 16'd0);

        // R7 directed: valid clear and expiring strobe in the same cycle
        do_reset();
        idle_edge();
        we = 1'b1; addr = 8'h00; wdata = 16'h8000;
        idle_edge();
        we = 1'b1; addr = 8'h10; wdata = 16'h4000;
        for (int k = 0; k < 19; k++) begin
            idle_edge();
            fetch = 1'b1;
        end
        idle_edge();
        fetch = 1'b1; we = 1'b1; addr = 8'h20; wdata = 16'h0008;
        rd_chk(7, 8'h30, 16'h0000);
        rd_chk(7, 8'h40, 16'h0000);

        // R10 directed: clear while disabled leaves counter alone
        idle_edge();
        we = 1'b1; addr = 8'h00; wdata = 16'h0000;
        idle_edge();
        idle_edge();
        we = 1'b1; addr = 8'h20; wdata = 16'h0008;
        rd_chk(10, 8'h30, 16'h0000);

        idle_edge();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R0 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule